// File: doc/BRIEF.md
# Multi-Channel Serial Controller Shared Control Registers

This block is the shared register set of a four-channel serial controller. A byte-wide register bus with an address, a write strobe, a read strobe, write data and combinational read data reaches three functions. The first is a 16-bit down-counting timer with a reload value, a control register and an interrupt. The second is a per-channel choice between 16x and 8x oversampling. The third is a per-channel software reset, which gives a single-cycle reset pulse to the chosen channels.

Writes take effect at the clock edge on which the write strobe is high. Read data follows the address without delay. A read of the timer control register clears the pending timer interrupt at the edge that ends the read. The channel logic, the bus bridge and the interrupt combining are outside this block.

Top module: `uart_gctl`

## Requirements
- R1: After reset every register reads 0x00, the oversampling selects and channel reset pulses are all low, and the timer interrupt is low. Unmapped addresses 5 to 7 read 0x00.
- R2: The reload value low byte is at address 1 and the high byte is at address 2. Together they form bits 7:0 and 15:8 of the reload value. Reading either address returns the programmed byte, never the live count.
- R3: The oversampling register is at address 3. Bit n drives ovsSel[n] for channel n: 0 selects 16x and 1 selects 8x. Bits 7:4 read as 0.
- R4: Writing address 4 with bit n set raises chanRst[n] for exactly the one cycle after the write edge. Bits written as 0 and bits 7:4 have no effect, and the register always reads 0x00.
- R5: The timer control register is at address 0. Bit 0 is enable, bit 1 selects periodic (1) or one-shot (0) mode, and bit 2 is the read-only pending flag. The other bits read 0. Writing it with bit 0 set loads the counter from the reload value.
- R6: With reload value N and nonzero N, the interrupt rises N cycles after the enabling write edge. In periodic mode it rises again every N cycles.
- R7: In one-shot mode the counter stops at zero and clears the enable bit, and no further interrupt follows.
- R8: A control register read returns the pending flag and clears it at the edge that ends the read. If the counter expires on that same edge, the flag stays set.
- R9: A reload value of zero keeps the timer idle even when it is enabled, and no interrupt is raised.
- R10: A reload byte written while the timer runs does not change the current period. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| ovsSel | output | 4 | Per-channel oversampling select, 1 = 8x |
| chanRst | output | 4 | Per-channel single-cycle reset pulse |
| timerIrq | output | 1 | Timer interrupt pending |

## Verification
The hardest case to reach is a control register read that lands on the very edge where the counter expires. Here the clear and the set compete, and the set must win. The bench enables a periodic timer with a reload of 3 from a known edge. It then counts negative edges so that the read strobe covers exactly the third edge after enabling. It expects the read to return the flag still clear while the interrupt stays high afterwards. A similar edge count places a reload write inside a running period, so that the old period finishes before the new one starts.

// File: rtl/uart_gctl_pkg.sv
package uart_gctl_pkg;

  localparam int ADR_CTL = 0;
  localparam int ADR_LO  = 1;
  localparam int ADR_HI  = 2;
  localparam int ADR_OVS = 3;
  localparam int ADR_RST = 4;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_CTL  = 3'd1,
    RD_LO   = 3'd2,
    RD_HI   = 3'd3,
    RD_OVS  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrLo;
    logic   wrHi;
    logic   wrOvs;
    logic   wrRst;
    logic   rdCtl;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gctl_ctrl.sv
module gctl_ctrl
  import uart_gctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           stb
);

  logic hitCtl, hitLo, hitHi, hitOvs, hitRst;

  always_comb begin
    hitCtl = (busAddr == ADDR_W'(ADR_CTL));
    hitLo  = (busAddr == ADDR_W'(ADR_LO));
    hitHi  = (busAddr == ADDR_W'(ADR_HI));
    hitOvs = (busAddr == ADDR_W'(ADR_OVS));
    hitRst = (busAddr == ADDR_W'(ADR_RST));

    stb.wrCtl = busWr && hitCtl;
    stb.wrLo  = busWr && hitLo;
    stb.wrHi  = busWr && hitHi;
    stb.wrOvs = busWr && hitOvs;
    stb.wrRst = busWr && hitRst;
    stb.rdCtl = busRd && hitCtl;

    if (hitCtl)      stb.rdSel = RD_CTL;
    else if (hitLo)  stb.rdSel = RD_LO;
    else if (hitHi)  stb.rdSel = RD_HI;
    else if (hitOvs) stb.rdSel = RD_OVS;
    else             stb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/gctl_dp.sv
module gctl_dp
  import uart_gctl_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    ovsSel,
  output logic [NCH-1:0]    chanRst,
  output logic              timerIrq
);

  localparam int TMR_W = 2 * DATA_W;

  logic [TMR_W-1:0] reloadVal;
  logic [TMR_W-1:0] cnt;
  logic             tmrEn;
  logic             tmrPeriodic;
  logic             irqFlag;
  logic [NCH-1:0]   ovsReg;
  logic [NCH-1:0]   rstPulse;
  logic             reloadNz;
  logic             doCount;
  logic             hitZero;
  logic             needLoad;

  always_comb begin
    reloadNz = |reloadVal;
    doCount  = tmrEn && reloadNz && (cnt != '0);
    hitZero  = doCount && (cnt == TMR_W'(1));
    needLoad = tmrEn && reloadNz && (cnt == '0);
  end

  // reload value bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else begin
      if (stb.wrLo) reloadVal[DATA_W-1:0]     <= busWdata;
      if (stb.wrHi) reloadVal[TMR_W-1:DATA_W] <= busWdata;
    end
  end

  // timer control and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrEn       <= 1'b0;
      tmrPeriodic <= 1'b0;
      cnt         <= '0;
    end else if (stb.wrCtl) begin
      tmrEn       <= busWdata[0];
      tmrPeriodic <= busWdata[1];
      if (busWdata[0]) cnt <= reloadVal;
    end else if (hitZero) begin
      if (tmrPeriodic) begin
        cnt <= reloadVal;
      end else begin
        cnt   <= '0;
        tmrEn <= 1'b0;
      end
    end else if (doCount) begin
      cnt <= cnt - TMR_W'(1);
    end else if (needLoad) begin
      cnt <= reloadVal;
    end
  end

  // pending flag: expiry wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irqFlag <= 1'b0;
    else if (hitZero)    irqFlag <= 1'b1;
    else if (stb.rdCtl)  irqFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ovsReg <= '0;
    else if (stb.wrOvs) ovsReg <= busWdata[NCH-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rst
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rstPulse[ch] <= 1'b0;
      else       rstPulse[ch] <= stb.wrRst && busWdata[ch];
    end

    // R4
    rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      rstPulse[ch] |-> ($past(stb.wrRst) && $past(busWdata[ch])));
  end

  always_comb begin
    case (stb.rdSel)
      RD_CTL:  busRdata = DATA_W'({irqFlag, tmrPeriodic, tmrEn});
      RD_LO:   busRdata = reloadVal[DATA_W-1:0];
      RD_HI:   busRdata = reloadVal[TMR_W-1:DATA_W];
      RD_OVS:  busRdata = DATA_W'(ovsReg);
      default: busRdata = '0;
    endcase
  end

  assign ovsSel   = ovsReg;
  assign chanRst  = rstPulse;
  assign timerIrq = irqFlag;

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdCtl && !hitZero) |=> !irqFlag);

  // R9
  zero_reload_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && !irqFlag) |=> !irqFlag);

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitZero && !tmrPeriodic && !stb.wrCtl) |=> (!tmrEn && cnt == '0));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmrEn && reloadNz && cnt > TMR_W'(1) && !stb.wrCtl)
      |=> (cnt == $past(cnt) - TMR_W'(1)));

endmodule

// File: rtl/uart_gctl.sv
module uart_gctl
  import uart_gctl_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    ovsSel,
  output logic [NCH-1:0]    chanRst,
  output logic              timerIrq
);

  strobe_t stb;

  gctl_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  gctl_dp #(.NCH(NCH), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .ovsSel   (ovsSel),
    .chanRst  (chanRst),
    .timerIrq (timerIrq)
  );

endmodule

// File: tb/uart_gctl_tb_top.sv
`timescale 1ns/1ps
module uart_gctl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] ovsSel;
  logic [3:0] chanRst;
  logic       timerIrq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_gctl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .ovsSel(ovsSel),
    .chanRst(chanRst), .timerIrq(timerIrq)
  );

  // {addr, write data, expected read}
  localparam logic [18:0] VEC [9] = '{
    {3'd1, 8'hA5, 8'hA5},   // R2
    {3'd2, 8'h3C, 8'h3C},   // R2
    {3'd3, 8'hFF, 8'h0F},   // R3
    {3'd3, 8'h05, 8'h05},   // R3
    {3'd4, 8'h0F, 8'h00},   // R4
    {3'd0, 8'hF8, 8'h00},   // R5
    {3'd0, 8'h02, 8'h02},   // R5
    {3'd5, 8'hFF, 8'h00},   // R1
    {3'd7, 8'h11, 8'h00}    // R1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and return at a negative edge
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1 busWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stopTimer();
    logic [7:0] tmp;
    busWrite(3'd0, 8'h00);
    busRead(3'd0, tmp);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    #12 rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 16'(timerIrq), 16'h0);
    check("R1 ovsSel", 16'(ovsSel), 16'h0);
    check("R1 chanRst", 16'(chanRst), 16'h0);
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), rd);
      check("R1 register", 16'(rd), 16'h0);
    end

    // table walk: write then read back
    for (int v = 0; v < 9; v++) begin
      busWrite(VEC[v][18:16], VEC[v][15:8]);
      busRead(VEC[v][18:16], rd);
      check("R2/R3/R4/R5 readback", 16'(rd), 16'(VEC[v][7:0]));
    end
    check("R3 ovsSel", 16'(ovsSel), 16'h5);

    // R4 pulse width and zero bits
    busWrite(3'd4, 8'h05);
    check("R4 pulse", 16'(chanRst), 16'h5);
    @(negedge clk);
    check("R4 pulse end", 16'(chanRst), 16'h0);
    busWrite(3'd4, 8'hF0);
    check("R4 zero bits", 16'(chanRst), 16'h0);
    check("R3 kept", 16'(ovsSel), 16'h5);

    // R6 periodic timer, reload 5
    busWrite(3'd1, 8'd5);
    busWrite(3'd2, 8'd0);
    busWrite(3'd0, 8'h03);
    waitNeg(4);
    check("R6 before expiry", 16'(timerIrq), 16'h0);
    waitNeg(1);
    check("R6 expiry", 16'(timerIrq), 16'h1);
    busRead(3'd0, rd);
    check("R8 read flag", 16'(rd), 16'h07);
    check("R8 cleared", 16'(timerIrq), 16'h0);
    waitNeg(3);
    check("R6 second period early", 16'(timerIrq), 16'h0);
    waitNeg(1);
    check("R6 second period", 16'(timerIrq), 16'h1);
    stopTimer();

    // R8 read on the expiry edge, reload 3
    busWrite(3'd1, 8'd3);
    busWrite(3'd0, 8'h03);
    waitNeg(2);
    busRead(3'd0, rd);
    check("R8 read before set", 16'(rd), 16'h03);
    check("R8 set wins", 16'(timerIrq), 16'h1);
    stopTimer();
    check("R8 stopped clear", 16'(timerIrq), 16'h0);

    // R7 one-shot, reload 3
    busWrite(3'd0, 8'h01);
    waitNeg(3);
    check("R7 expiry", 16'(timerIrq), 16'h1);
    busRead(3'd0, rd);
    check("R7 enable cleared", 16'(rd), 16'h04);
    waitNeg(10);
    check("R7 no repeat", 16'(timerIrq), 16'h0);
    busRead(3'd1, rd);
    check("R2 reload kept", 16'(rd), 16'h03);

    // R10 reload change mid-period: 10 then 4
    busWrite(3'd1, 8'd10);
    busWrite(3'd0, 8'h03);
    busWrite(3'd1, 8'd4);
    busRead(3'd1, rd);
    check("R2 reads programmed not count", 16'(rd), 16'h04);
    waitNeg(7);
    check("R10 old period early", 16'(timerIrq), 16'h0);
    waitNeg(1);
    check("R10 old period", 16'(timerIrq), 16'h1);
    busRead(3'd0, rd);
    check("R10 flag read", 16'(rd), 16'h07);
    waitNeg(2);
    check("R10 new period early", 16'(timerIrq), 16'h0);
    waitNeg(1);
    check("R10 new period", 16'(timerIrq), 16'h1);
    stopTimer();

    // R9 zero reload stays idle
    busWrite(3'd1, 8'd0);
    busWrite(3'd2, 8'd0);
    busWrite(3'd0, 8'h03);
    waitNeg(20);
    check("R9 no irq", 16'(timerIrq), 16'h0);
    busRead(3'd0, rd);
    check("R9 ctrl", 16'(rd), 16'h03);

    // R2 high byte weight: reload 0x0100 not expired after 255 cycles
    busWrite(3'd2, 8'd1);
    busWrite(3'd0, 8'h01);
    waitNeg(255);
    check("R2 high byte early", 16'(timerIrq), 16'h0);
    waitNeg(1);
    check("R2 high byte expiry", 16'(timerIrq), 16'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule